// File: doc/BRIEF.md
# Infrared Remote Frame Transmitter

This block drives one output pin with a modulated infrared remote-control frame. A carrier of programmable period and high time is gated on or off by a frame sequencer. Each frame has three sections. The lead section is a variable-length bit pattern. The payload section holds up to 64 bits, and every bit is sent as a pre segment followed by a post segment. The gap section is silent. The frame is sent a programmed number of times.

Two parameter banks hold the lead, payload and gap settings. The first frame always comes from bank 0. An update request issued during transmission switches to bank 1 at the next frame boundary. After that switch, bank 1 is either held for every later frame or alternated with bank 0, depending on the mode bit. Software loads every setting through a simple write port. A start pulse begins transmission and a stop pulse ends it at the end of the current frame. One-cycle events mark the start of transmission and the completion of all frames.

Top module: `ir_frame_tx`

## Requirements
- R1: Write port map (data on wr_data):
  - Address 0: bit 0 is the cycle-mode flag.
  - Address 1: carrier period in clocks.
  - Address 2: carrier high time in clocks.
  - Address 3: frame count.
  - Addresses 4 to 7: symbol words for logic-0 pre, logic-0 post, logic-1 pre and logic-1 post, in that order.
  - Bank b occupies addresses 8+8*b to 13+8*b, holding in order: lead pattern, lead unit, payload length, payload bits 31:0, payload bits 63:32, gap units.
  - Reset values: period RST_PER, high time RST_PER/3 (integer division), frame count 1, all other settings 0.
- R2: While busy is low, ir_out is low. After reset, busy, evt_start and evt_done are low.
- R3: One carrier cycle lasts P clocks, where P is the period (0 behaves as 1). During an on segment, ir_out is high for the first H clocks of each carrier cycle, where H is the high time (H of P or more means the whole cycle). Writing the period also sets the high time to period/3; a later high-time write overrides it.
- R4: The lead section sends the pattern from its highest set bit down to bit 0. Each lead bit lasts the lead unit in carrier cycles. A lead bit of 1 sends carrier and a lead bit of 0 sends idle. A zero pattern gives no lead section.
- R5: Payload bits are sent starting from bit 0 of the low word. Bits 32 to 63 come from the high word. The payload length is capped at 64.
  - Each bit sends the pre word and then the post word that belong to its value.
  - In a symbol word, bit 16 is the level (1 = carrier, 0 = idle) and bits 15:0 are the duration in carrier cycles (0 behaves as 1).
- R6: After the payload comes an idle gap of G lead-unit periods, where G is the gap units value (0 behaves as 1). A lead unit of 0 behaves as 1.
- R7: A start sends N frames, where N is the frame count (0 behaves as 1). Busy stays high for exactly the total carrier cycles of those frames times P clocks.
- R8: evt_start is a one-cycle pulse in the first busy cycle. evt_done is a one-cycle pulse in the first idle cycle after transmission ends.
- R9: Without an update request, every frame uses bank 0. When the cycle-mode flag is 0, an update request while busy makes every frame after the next boundary use bank 1.
- R10: When the cycle-mode flag is 1, an update request while busy makes the frames alternate between banks, starting with bank 1 at the next boundary.
- R11: A stop request while busy ends transmission at the end of the current frame and raises evt_done.
- R12: A start while busy has no effect: no second evt_start, and the total length is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| start | input | 1 | Begin transmission (ignored while busy) |
| stop | input | 1 | End after the current frame |
| update | input | 1 | Switch to bank 1 at the next frame boundary |
| ir_out | output | 1 | Modulated infrared output |
| busy | output | 1 | Transmission in progress |
| evt_start | output | 1 | Start-of-send event pulse |
| evt_done | output | 1 | All-done event pulse |

## Verification
The assertions check the handshake between busy and the two events on every cycle: each event coincides with the matching busy edge, and neither event appears at any other time. They also check that the pin stays quiet whenever the block is idle. Some behaviours can only be shown by the bench's scenarios:
- the bit order of the lead and the payload;
- the symbol and gap lengths;
- the exact number of clocks in a frame train;
- the bank sequence under the two modes;
- the effect of stop and of a second start.

The bench measures these through busy length, counts of high clocks and samples at chosen cycles.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
    localparam int DURW   = 16;
    localparam int LEADW  = 32;
    localparam int LIDXW  = $clog2(LEADW);
    localparam int LENW   = 7;
    localparam int MAXPAY = 64;
    localparam int PIDXW  = $clog2(MAXPAY);
    localparam int CNTW   = 16;
    localparam int FRW    = 8;
    localparam int ADDRW  = 5;
    localparam int DATAW  = 32;

    typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_PRE, ST_POST, ST_GAP} seq_st_e;

    typedef struct packed {
        logic            on;
        logic [DURW-1:0] len;
    } seg_word_t;

    typedef struct packed {
        logic [LEADW-1:0]  lead;
        logic [DURW-1:0]   unit;
        logic [LENW-1:0]   plen;
        logic [MAXPAY-1:0] data;
        logic [DURW-1:0]   gap;
    } bank_cfg_t;

    typedef struct packed {
        seq_st_e         st;
        logic [DURW-1:0] idx;
    } pos_t;

    // First section of a frame: lead (top set bit first), else payload, else gap.
    function automatic pos_t frame_entry(bank_cfg_t c);
        pos_t            p;
        logic [DURW-1:0] n;
        n = '0;
        for (int i = 0; i < LEADW; i++) begin
            if (c.lead[i]) n = DURW'(i + 1);
        end
        if (n != '0) begin
            p.st  = ST_LEAD;
            p.idx = n - DURW'(1);
        end else if (c.plen != '0) begin
            p.st  = ST_PRE;
            p.idx = '0;
        end else begin
            p.st  = ST_GAP;
            p.idx = '0;
        end
        return p;
    endfunction
endpackage

// File: rtl/ir_tx_regs.sv
module ir_tx_regs
    import ir_tx_pkg::*;
#(
    parameter int RST_PER = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDRW-1:0]     wr_addr,
    input  logic [DATAW-1:0]     wr_data,
    output logic                 cyc_mode,
    output logic [CNTW-1:0]      per,
    output logic [CNTW-1:0]      hi,
    output logic [FRW-1:0]       frames,
    output seg_word_t [3:0]      sym,
    output bank_cfg_t [1:0]      bank
);
    localparam logic [CNTW-1:0] RST_HI = CNTW'(RST_PER / 3);

    typedef struct packed {
        logic            cyc;
        logic [CNTW-1:0] per;
        logic [CNTW-1:0] hi;
        logic [FRW-1:0]  frames;
        seg_word_t [3:0] sym;
        bank_cfg_t [1:0] bank;
    } regs_t;

    regs_t r_q, r_d;
    logic  bi;

    always_comb begin
        r_d = r_q;
        bi  = wr_addr[4];
        if (wr_en) begin
            if (wr_addr[4:3] == 2'b00) begin
                case (wr_addr[2:0])
                    3'd0: r_d.cyc    = wr_data[0];
                    3'd1: begin
                        r_d.per = wr_data[CNTW-1:0];
                        r_d.hi  = wr_data[CNTW-1:0] / CNTW'(3);
                    end
                    3'd2: r_d.hi     = wr_data[CNTW-1:0];
                    3'd3: r_d.frames = wr_data[FRW-1:0];
                    default: r_d.sym[wr_addr[1:0]] = '{on: wr_data[16], len: wr_data[DURW-1:0]};
                endcase
            end else if (wr_addr[4] != wr_addr[3]) begin
                case (wr_addr[2:0])
                    3'd0: r_d.bank[bi].lead              = wr_data[LEADW-1:0];
                    3'd1: r_d.bank[bi].unit              = wr_data[DURW-1:0];
                    3'd2: r_d.bank[bi].plen              = wr_data[LENW-1:0];
                    3'd3: r_d.bank[bi].data[31:0]        = wr_data;
                    3'd4: r_d.bank[bi].data[63:32]       = wr_data;
                    3'd5: r_d.bank[bi].gap               = wr_data[DURW-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.per    <= CNTW'(RST_PER);
            r_q.hi     <= RST_HI;
            r_q.frames <= FRW'(1);
        end else begin
            r_q <= r_d;
        end
    end

    assign cyc_mode = r_q.cyc;
    assign per      = r_q.per;
    assign hi       = r_q.hi;
    assign frames   = r_q.frames;
    assign sym      = r_q.sym;
    assign bank     = r_q.bank;
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier
    import ir_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            active,
    input  logic [CNTW-1:0] per,
    input  logic [CNTW-1:0] hi,
    output logic            tick,
    output logic            car_on
);
    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = active && (({1'b0, cnt_q} + (CNTW+1)'(1)) >= {1'b0, per});
        cnt_d = cnt_q;
        if (!active || tick) cnt_d = '0;
        else                 cnt_d = cnt_q + CNTW'(1);
    end

    assign car_on = cnt_q < hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq
    import ir_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic            update,
    input  logic            cyc_mode,
    input  logic [FRW-1:0]  frames,
    input  seg_word_t [3:0] sym,
    input  bank_cfg_t [1:0] bank,
    input  logic            tick,
    output logic            busy,
    output logic            seg_on,
    output logic            evt_start,
    output logic            evt_done
);
    typedef struct packed {
        seq_st_e         st;
        logic [DURW-1:0] idx;
        logic [DURW-1:0] seg;
        logic [FRW-1:0]  fcnt;
        logic            bsel;
        logic            armed;
        logic            stop_pend;
        logic            evs;
        logic            evd;
    } seq_t;

    seq_t            s_q, s_d;
    bank_cfg_t       cur;
    seg_word_t       w;
    logic            bitv, seg_end, last_frame, nb, idx_last;
    logic [LENW-1:0] plen_eff;
    pos_t            ent0, entn;

    always_comb begin
        s_d      = s_q;
        s_d.evs  = 1'b0;
        s_d.evd  = 1'b0;
        cur      = bank[s_q.bsel];
        plen_eff = (cur.plen > LENW'(MAXPAY)) ? LENW'(MAXPAY) : cur.plen;
        bitv     = cur.data[s_q.idx[PIDXW-1:0]];
        case (s_q.st)
            ST_LEAD: w = '{on: cur.lead[s_q.idx[LIDXW-1:0]], len: cur.unit};
            ST_PRE:  w = sym[{bitv, 1'b0}];
            ST_POST: w = sym[{bitv, 1'b1}];
            ST_GAP:  w = '{on: 1'b0, len: cur.unit};
            default: w = '0;
        endcase
        seg_end    = tick && (({1'b0, s_q.seg} + (DURW+1)'(1)) >= {1'b0, w.len});
        last_frame = s_q.stop_pend || (({1'b0, s_q.fcnt} + (FRW+1)'(1)) >= {1'b0, frames});
        nb         = s_q.armed ? (cyc_mode ? ~s_q.bsel : 1'b1) : s_q.bsel;
        ent0       = frame_entry(bank[0]);
        entn       = frame_entry(bank[nb]);
        idx_last   = 1'b0;

        if (s_q.st == ST_IDLE) begin
            if (start) begin
                s_d.st        = ent0.st;
                s_d.idx       = ent0.idx;
                s_d.seg       = '0;
                s_d.fcnt      = '0;
                s_d.bsel      = 1'b0;
                s_d.armed     = 1'b0;
                s_d.stop_pend = 1'b0;
                s_d.evs       = 1'b1;
            end
        end else begin
            if (update) s_d.armed     = 1'b1;
            if (stop)   s_d.stop_pend = 1'b1;
            if (tick)   s_d.seg       = s_q.seg + DURW'(1);
            if (seg_end) begin
                s_d.seg = '0;
                case (s_q.st)
                    ST_LEAD: begin
                        if (s_q.idx == '0) begin
                            s_d.st  = (plen_eff != '0) ? ST_PRE : ST_GAP;
                            s_d.idx = '0;
                        end else begin
                            s_d.idx = s_q.idx - DURW'(1);
                        end
                    end
                    ST_PRE: s_d.st = ST_POST;
                    ST_POST: begin
                        idx_last = (({1'b0, s_q.idx} + (DURW+1)'(1)) >= (DURW+1)'(plen_eff));
                        s_d.st   = idx_last ? ST_GAP : ST_PRE;
                        s_d.idx  = idx_last ? '0 : s_q.idx + DURW'(1);
                    end
                    ST_GAP: begin
                        idx_last = (({1'b0, s_q.idx} + (DURW+1)'(1)) >= {1'b0, cur.gap});
                        if (!idx_last) begin
                            s_d.idx = s_q.idx + DURW'(1);
                        end else if (last_frame) begin
                            s_d.st        = ST_IDLE;
                            s_d.idx       = '0;
                            s_d.armed     = 1'b0;
                            s_d.stop_pend = 1'b0;
                            s_d.evd       = 1'b1;
                        end else begin
                            s_d.fcnt = s_q.fcnt + FRW'(1);
                            s_d.bsel = nb;
                            s_d.st   = entn.st;
                            s_d.idx  = entn.idx;
                        end
                    end
                    default: s_d.st = ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign seg_on    = w.on;
    assign evt_start = s_q.evs;
    assign evt_done  = s_q.evd;
endmodule

// File: rtl/ir_frame_tx.sv
module ir_frame_tx
    import ir_tx_pkg::*;
#(
    parameter int RST_PER = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADDRW-1:0] wr_addr,
    input  logic [DATAW-1:0] wr_data,
    input  logic             start,
    input  logic             stop,
    input  logic             update,
    output logic             ir_out,
    output logic             busy,
    output logic             evt_start,
    output logic             evt_done
);
    logic            cyc_mode, tick, car_on, seg_on;
    logic [CNTW-1:0] per, hi;
    logic [FRW-1:0]  frames;
    seg_word_t [3:0] sym;
    bank_cfg_t [1:0] bank;

    ir_tx_regs #(.RST_PER(RST_PER)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cyc_mode(cyc_mode), .per(per), .hi(hi), .frames(frames), .sym(sym), .bank(bank)
    );

    ir_tx_carrier u_car (
        .clk(clk), .rst_n(rst_n), .active(busy), .per(per), .hi(hi),
        .tick(tick), .car_on(car_on)
    );

    ir_tx_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .update(update),
        .cyc_mode(cyc_mode), .frames(frames), .sym(sym), .bank(bank), .tick(tick),
        .busy(busy), .seg_on(seg_on), .evt_start(evt_start), .evt_done(evt_done)
    );

    assign ir_out = busy & seg_on & car_on;
endmodule

// File: rtl/ir_frame_tx_chk.sv
module ir_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic ir_out,
    input logic busy,
    input logic evt_start,
    input logic evt_done
);
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !ir_out); // R2
    AST_START_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n) evt_start |-> $rose(busy)); // R8
    AST_RISE_HAS_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> evt_start); // R8
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) evt_done |-> $fell(busy)); // R8
    AST_FALL_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> evt_done); // R11
    AST_NO_RESTART_EVT: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> !evt_start); // R12
endmodule

bind ir_frame_tx ir_frame_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ir_out(ir_out), .busy(busy),
    .evt_start(evt_start), .evt_done(evt_done)
);

// File: tb/tb_ir_frame_tx.sv
module tb_ir_frame_tx;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        int unsigned per;
        int unsigned hi;
        int unsigned lead;
        int unsigned lu;
        int unsigned s0a;
        int unsigned s0b;
        int unsigned s1a;
        int unsigned s1b;
        int unsigned plen;
        logic [63:0] data;
        int unsigned gap;
        int unsigned frames;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{per: 4, hi: 0, lead: 5, lu: 2, s0a: 'h10001, s0b: 3, s1a: 'h10001, s1b: 1,
          plen: 8, data: 64'hA5, gap: 2, frames: 1},
        '{per: 6, hi: 3, lead: 0, lu: 1, s0a: 2, s0b: 'h10002, s1a: 'h10003, s1b: 1,
          plen: 40, data: 64'h0000_00F0_1234_5678, gap: 0, frames: 2},
        '{per: 3, hi: 5, lead: 1, lu: 3, s0a: 'h10000, s0b: 0, s1a: 0, s1b: 'h10002,
          plen: 0, data: 64'h0, gap: 1, frames: 3},
        '{per: 5, hi: 2, lead: 32'h8000_0001, lu: 1, s0a: 'h10001, s0b: 1, s1a: 'h10002, s1b: 2,
          plen: 64, data: 64'hFFFF_0000_AAAA_5555, gap: 3, frames: 1}
    };

    localparam vec_t VRST = '{per: 12, hi: 0, lead: 1, lu: 1, s0a: 0, s0b: 0, s1a: 0, s1b: 0,
                              plen: 0, data: 64'h0, gap: 1, frames: 1};
    localparam vec_t VLEAD = '{per: 4, hi: 2, lead: 2, lu: 2, s0a: 0, s0b: 0, s1a: 0, s1b: 0,
                               plen: 0, data: 64'h0, gap: 1, frames: 1};
    localparam vec_t VPAY = '{per: 4, hi: 2, lead: 0, lu: 1, s0a: 1, s0b: 'h10001, s1a: 'h10001, s1b: 1,
                              plen: 2, data: 64'h1, gap: 1, frames: 1};
    localparam vec_t VB0 = '{per: 4, hi: 2, lead: 1, lu: 2, s0a: 0, s0b: 0, s1a: 0, s1b: 0,
                             plen: 0, data: 64'h0, gap: 1, frames: 3};
    localparam vec_t VB1 = '{per: 4, hi: 2, lead: 3, lu: 2, s0a: 0, s0b: 0, s1a: 0, s1b: 0,
                             plen: 0, data: 64'h0, gap: 2, frames: 3};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0, stop = 1'b0, update = 1'b0;
    logic        ir_out, busy, evt_start, evt_done;

    int checks = 0;
    int errors = 0;

    ir_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .stop(stop), .update(update),
        .ir_out(ir_out), .busy(busy), .evt_start(evt_start), .evt_done(evt_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int unsigned u1(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    // Independent frame model: carrier cycles per frame and on carrier cycles per frame.
    function automatic void model(input vec_t v, output int unsigned car, output int unsigned onc);
        int unsigned ll = 0;
        int unsigned pl;
        int unsigned pre, post;
        for (int i = 0; i < 32; i++) if (v.lead[i]) ll = i + 1;
        car = ll * u1(v.lu);
        onc = $countones(v.lead) * u1(v.lu);
        pl  = (v.plen > 64) ? 64 : v.plen;
        for (int i = 0; i < int'(pl); i++) begin
            pre  = v.data[i] ? v.s1a : v.s0a;
            post = v.data[i] ? v.s1b : v.s0b;
            car += u1(pre & 'hFFFF) + u1(post & 'hFFFF);
            if (pre[16])  onc += u1(pre & 'hFFFF);
            if (post[16]) onc += u1(post & 'hFFFF);
        end
        car += u1(v.gap) * u1(v.lu);
    endfunction

    function automatic int unsigned hclk(input vec_t v);
        int unsigned h = (v.hi == 0) ? v.per / 3 : v.hi;
        return (h > u1(v.per)) ? u1(v.per) : h;
    endfunction

    task automatic wr(input int addr, input int unsigned data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_common(input vec_t v, input int mode);
        wr(0, mode); wr(1, v.per);
        if (v.hi != 0) wr(2, v.hi);
        wr(3, v.frames);
        wr(4, v.s0a); wr(5, v.s0b); wr(6, v.s1a); wr(7, v.s1b);
    endtask

    task automatic load_bank(input vec_t v, input int b);
        int base = (b != 0) ? 16 : 8;
        wr(base + 0, v.lead); wr(base + 1, v.lu); wr(base + 2, v.plen);
        wr(base + 3, v.data[31:0]); wr(base + 4, v.data[63:32]); wr(base + 5, v.gap);
    endtask

    task automatic run(input int upd_at, input int stop_at, input int again_at, input int probe_at,
                       output int cyc, output int hic, output int nst, output bit dn,
                       output bit first, output bit probe);
        cyc = 0; hic = 0; nst = 0; dn = 0; first = 0; probe = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        first = ir_out;
        while (busy && cyc < 100000) begin
            if (ir_out) hic++;
            if (evt_start) nst++;
            if (cyc == probe_at) probe = ir_out;
            update = (cyc == upd_at);
            stop   = (cyc == stop_at);
            start  = (cyc == again_at);
            cyc++;
            @(negedge clk);
        end
        update = 1'b0; stop = 1'b0; start = 1'b0;
        dn = evt_done;
    endtask

    initial begin
        int cyc, hic, nst;
        bit dn, first, probe;
        int unsigned car, onc, car1, onc1;

        repeat (4) @(negedge clk);
        chk("R2 busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 ir_out after reset", ir_out, 0);
        chk("R2 evt_start after reset", evt_start, 0);
        chk("R2 evt_done after reset", evt_done, 0);

        // R1 reset values: period 12, high 4, one frame
        load_bank(VRST, 0);
        run(-1, -1, -1, -1, cyc, hic, nst, dn, first, probe);
        chk("R1 reset period busy clocks", cyc, 24);
        chk("R1 reset high time clocks", hic, 4);

        // Table of vectors
        for (int k = 0; k < 4; k++) begin
            load_common(VECS[k], 0);
            load_bank(VECS[k], 0);
            model(VECS[k], car, onc);
            run(-1, -1, -1, -1, cyc, hic, nst, dn, first, probe);
            chk($sformatf("R7 R6 vec%0d busy clocks", k), cyc, car * u1(VECS[k].per) * VECS[k].frames);
            chk($sformatf("R5 R3 vec%0d on clocks", k), hic, onc * hclk(VECS[k]) * VECS[k].frames);
            chk($sformatf("R8 vec%0d start events", k), nst, 1);
            chk($sformatf("R8 vec%0d done event", k), dn, 1);
            chk($sformatf("R2 vec%0d idle output", k), ir_out, 0);
        end

        // R4 lead order
        load_common(VLEAD, 0);
        load_bank(VLEAD, 0);
        run(-1, -1, -1, 8, cyc, hic, nst, dn, first, probe);
        chk("R4 lead top bit carrier", first, 1);
        chk("R4 lead bit0 idle", probe, 0);
        chk("R4 lead frame clocks", cyc, 24);

        // R5 payload order
        load_common(VPAY, 0);
        load_bank(VPAY, 0);
        run(-1, -1, -1, 4, cyc, hic, nst, dn, first, probe);
        chk("R5 payload bit0 pre first", first, 1);
        chk("R5 payload bit0 post idle", probe, 0);

        // Bank behaviour: bank0 frame 16 clocks, bank1 frame 32 clocks
        load_common(VB0, 0);
        load_bank(VB0, 0);
        load_bank(VB1, 1);
        model(VB0, car, onc);
        model(VB1, car1, onc1);
        run(-1, -1, -1, -1, cyc, hic, nst, dn, first, probe);
        chk("R9 no update all bank0", cyc, 3 * car * 4);
        run(3, -1, -1, -1, cyc, hic, nst, dn, first, probe);
        chk("R9 repeat mode holds bank1", cyc, car * 4 + 2 * car1 * 4);
        wr(0, 1);
        run(3, -1, -1, -1, cyc, hic, nst, dn, first, probe);
        chk("R10 cycle mode alternates", cyc, 2 * car * 4 + car1 * 4);
        wr(0, 0);

        // R11 stop ends at frame end
        wr(3, 5);
        run(-1, 3, -1, -1, cyc, hic, nst, dn, first, probe);
        chk("R11 stop after first frame", cyc, car * 4);
        chk("R11 stop raises done", dn, 1);

        // R12 start while busy ignored
        wr(3, 1);
        run(-1, -1, 5, -1, cyc, hic, nst, dn, first, probe);
        chk("R12 restart length unchanged", cyc, car * 4);
        chk("R12 no second start event", nst, 1);
        repeat (3) @(negedge clk);
        chk("R12 stays idle after ignored start", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule